// File: doc/BRIEF.md
# Posit8 / binary32 storage converter

This block converts between IEEE binary32 values and 8-bit posit codes. Weights and activations are kept in the dense 8-bit form in memory. All arithmetic stays in ordinary binary32. The block has two independent paths, and each one has a single registered valid/data stage.

The encode path takes a binary32 word and produces the nearest posit code. Rounding is done on the packed bit pattern, and out-of-range finite values saturate instead of collapsing to zero. The decode path takes a posit code and produces a binary32 word that represents the posit's value exactly.

The exponent-field width `ES` is fixed at elaboration and may be 1 or 2. Each regime step scales the value by 2^(2^ES).

Top module: `posit8_fp32_bridge`

## Requirements
- R1: Each path's output valid rises exactly one clock after its input valid and is low one clock after an idle input. The output data register keeps its last value while no input is valid. After synchronous reset both valids and both data outputs are zero.
- R2: Decode of a positive code (0x01..0x7F) is exact.
  - Bits 6..0 start with a run of m equal bits. A zero run gives regime k = -m and a ones run gives k = m-1.
  - The run ends at the first opposite bit, which is skipped, or at the end of the word.
  - The next ES bits form the exponent e. Missing exponent bits read as zero.
  - The remaining bits form the fraction f.
  - The value is 2^(k·2^ES + e)·(1+f).
- R3: Decode of code 0x00 gives 0x00000000, and decode of code 0x80 (not-a-real) gives the quiet NaN 0x7FC00000.
- R4: A code with bit 7 set, other than 0x80, decodes to the negation of the value of its two's complement, so the binary32 sign bit is set.
- R5: Encode of a finite value between minpos and maxpos gives the code whose value is nearest. The rounding boundary is the value of the 9-bit posit formed by appending a 1 bit. A value exactly on that boundary takes the code with bit 0 clear.
- R6: A finite nonzero input with magnitude at or above maxpos encodes to 0x7F (positive) or 0x81 (negative). A magnitude at or below minpos, including every binary32 subnormal, encodes to 0x01 or 0xFF. A finite nonzero input never yields 0x00 or 0x80.
- R7: +0 and -0 encode to 0x00. Any input with exponent field 0xFF (infinity or NaN) encodes to 0x80.
- R8: For every code c, encoding the exact binary32 image of c gives back c.
- R9: maxpos is 2^(6·2^ES) and minpos is its reciprocal, so the same binary32 input encodes differently for ES=1 and ES=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_vld_i | input | 1 | Encode request valid |
| enc_f32_i | input | 32 | binary32 value to encode |
| enc_vld_o | output | 1 | Encode result valid |
| enc_p8_o | output | 8 | Posit code result |
| dec_vld_i | input | 1 | Decode request valid |
| dec_p8_i | input | 8 | Posit code to decode |
| dec_vld_o | output | 1 | Decode result valid |
| dec_f32_o | output | 32 | binary32 result |

## Verification
The hardest case to reach is an exact rounding tie in the region where a long regime has pushed some or all exponent bits out of the word. In that region the pattern midpoint is not the arithmetic midpoint of the two neighbouring values. The stimulus builds each boundary value as the decoded value of a 9-bit posit ending in 1, for every adjacent code pair and both signs. It also applies the binary32 values one unit in the last place on either side of each boundary, and does this separately for ES=1 and ES=2. An exhaustive round trip over all 256 codes, saturation probes, subnormals and randomly gapped valid traffic complete the stimulus.

// File: rtl/p8cv_pkg.sv
`timescale 1ns/1ps
package p8cv_pkg;
  localparam int PW        = 8;            // posit word width
  localparam int BODY_W    = PW - 1;       // bits after the sign
  localparam int FX_W      = 8;            // binary32 exponent width
  localparam int FM_W      = 23;           // binary32 mantissa width
  localparam int FBIAS     = 127;
  localparam logic [PW-1:0] P8_NAR   = 8'h80;
  localparam logic [31:0]   F32_QNAN = 32'h7FC0_0000;
  localparam logic [FX_W-1:0] FX_SPECIAL = 8'hFF;
endpackage

// File: rtl/p8cv_run.sv
`timescale 1ns/1ps
// Length of the run of bits equal to the MSB, counted from the MSB.
module p8cv_run #(
  parameter int W  = 7,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] run_o
);
  always_comb begin
    logic stop;
    stop  = 1'b0;
    run_o = CW'(1);
    for (int i = W - 2; i >= 0; i--) begin
      if (!stop && (bits_i[i] == bits_i[W-1])) run_o = run_o + CW'(1);
      else stop = 1'b1;
    end
  end
endmodule

// File: rtl/p8cv_dec.sv
`timescale 1ns/1ps
module p8cv_dec
  import p8cv_pkg::*;
#(
  parameter int ES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld_i,
  input  logic [PW-1:0] code_i,
  output logic          vld_o,
  output logic [31:0]   f32_o
);
  localparam int USTEP     = 1 << ES;
  localparam int SCALE_MAX = (PW - 2) * USTEP;
  localparam int RW        = $clog2(BODY_W + 1);

  logic              sgn;
  logic [BODY_W-1:0] body;
  logic [RW-1:0]     run;
  logic [BODY_W-1:0] tail;
  logic [ES-1:0]     ex;
  logic [BODY_W-1:0] frac;
  logic [31:0]       nxt;

  assign sgn  = code_i[PW-1];
  // negative codes are the two's complement of their magnitude
  assign body = sgn ? BODY_W'(8'd0 - code_i) : code_i[BODY_W-1:0];

  p8cv_run #(.W(BODY_W), .CW(RW)) u_run (
    .bits_i (body),
    .run_o  (run)
  );

  always_comb begin
    int k;
    int scale;
    if (body[BODY_W-1]) k = int'(run) - 1;
    else                k = -int'(run);
    // drop regime plus terminator; cut exponent bits fill as zero
    tail  = body << ({1'b0, run} + (RW+1)'(1));
    ex    = tail[BODY_W-1 -: ES];
    frac  = tail << ES;
    scale = k * USTEP + int'(ex);
    if (code_i == 8'h00)       nxt = 32'h0;
    else if (code_i == P8_NAR) nxt = F32_QNAN;
    else nxt = {sgn, FX_W'(scale + FBIAS), frac, {(FM_W-BODY_W){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      f32_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) f32_o <= nxt;
    end
  end

  p_vld_follow_r1: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> vld_o);
  p_vld_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> !vld_o);
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> $stable(f32_o));
  p_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (vld_i && code_i == 8'h00) |=> (f32_o == 32'h0));
  p_nar_r3: assert property (@(posedge clk) disable iff (rst)
    (vld_i && code_i == P8_NAR) |=> (f32_o == F32_QNAN));
  p_sign_r4: assert property (@(posedge clk) disable iff (rst)
    (vld_i && code_i[BODY_W-1:0] != '0) |=> (f32_o[31] == $past(code_i[PW-1])));
  p_range_r9: assert property (@(posedge clk) disable iff (rst)
    (vld_i && code_i[BODY_W-1:0] != '0) |=>
      (f32_o[30:23] >= FX_W'(FBIAS - SCALE_MAX)) && (f32_o[30:23] <= FX_W'(FBIAS + SCALE_MAX)));
endmodule

// File: rtl/p8cv_enc.sv
`timescale 1ns/1ps
module p8cv_enc
  import p8cv_pkg::*;
#(
  parameter int ES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld_i,
  input  logic [31:0]   f32_i,
  output logic          vld_o,
  output logic [PW-1:0] p8_o
);
  localparam int USTEP     = 1 << ES;
  localparam int SCALE_MAX = (PW - 2) * USTEP;
  localparam int WV        = 40;            // staging width: regime + ES + mantissa + slack
  localparam int PAD       = WV - ES - FM_W;

  logic              sgn;
  logic [FX_W-1:0]   fexp;
  logic [FM_W-1:0]   fman;
  logic              is_spec, is_zero, is_sub;
  logic [ES-1:0]     eb;
  logic [WV-1:0]     regv, bodyv, v;
  logic [BODY_W-1:0] p7;
  logic              grd, stk;
  logic [PW-1:0]     rnd, mag, nxt;

  assign sgn     = f32_i[31];
  assign fexp    = f32_i[30:23];
  assign fman    = f32_i[22:0];
  assign is_spec = (fexp == FX_SPECIAL);
  assign is_zero = (fexp == '0) && (fman == '0);
  assign is_sub  = (fexp == '0) && (fman != '0);

  always_comb begin
    int scale;
    int k;
    int rlen;
    scale = int'(fexp) - FBIAS;
    k     = scale >>> ES;
    eb    = scale[ES-1:0];
    rlen  = (k >= 0) ? k + 2 : 1 - k;
    if (k >= 0) regv = ~({WV{1'b1}} >> (rlen - 1));
    else        regv = {1'b1, {(WV-1){1'b0}}} >> (rlen - 1);
    bodyv = {eb, fman, {PAD{1'b0}}} >> rlen;
    v     = regv | bodyv;
    p7    = v[WV-1 -: BODY_W];
    grd   = v[WV-1-BODY_W];
    stk   = |v[WV-2-BODY_W:0];
    rnd   = {1'b0, p7} + {{BODY_W{1'b0}}, grd & (stk | p7[0])};
    if (is_sub || scale < -SCALE_MAX) mag = 8'h01;
    else if (scale >= SCALE_MAX)      mag = 8'h7F;
    else                              mag = rnd;
    if (is_spec)      nxt = P8_NAR;
    else if (is_zero) nxt = 8'h00;
    else              nxt = sgn ? (8'd0 - mag) : mag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      p8_o  <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) p8_o <= nxt;
    end
  end

  p_vld_follow_r1: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> vld_o);
  p_vld_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> !vld_o);
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> $stable(p8_o));
  p_special_r7: assert property (@(posedge clk) disable iff (rst)
    (vld_i && f32_i[30:23] == FX_SPECIAL) |=> (p8_o == P8_NAR));
  p_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (vld_i && f32_i[30:0] == '0) |=> (p8_o == 8'h00));
  p_no_collapse_r6: assert property (@(posedge clk) disable iff (rst)
    (vld_i && f32_i[30:23] != FX_SPECIAL && f32_i[30:0] != '0) |=>
      (p8_o != 8'h00) && (p8_o != P8_NAR));
  p_sign_r6: assert property (@(posedge clk) disable iff (rst)
    (vld_i && f32_i[30:23] != FX_SPECIAL && f32_i[30:0] != '0) |=>
      (p8_o[PW-1] == $past(f32_i[31])));
endmodule

// File: rtl/posit8_fp32_bridge.sv
`timescale 1ns/1ps
module posit8_fp32_bridge
  import p8cv_pkg::*;
#(
  parameter int ES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enc_vld_i,
  input  logic [31:0]   enc_f32_i,
  output logic          enc_vld_o,
  output logic [PW-1:0] enc_p8_o,
  input  logic          dec_vld_i,
  input  logic [PW-1:0] dec_p8_i,
  output logic          dec_vld_o,
  output logic [31:0]   dec_f32_o
);
  p8cv_enc #(.ES(ES)) u_enc (
    .clk   (clk),
    .rst   (rst),
    .vld_i (enc_vld_i),
    .f32_i (enc_f32_i),
    .vld_o (enc_vld_o),
    .p8_o  (enc_p8_o)
  );

  p8cv_dec #(.ES(ES)) u_dec (
    .clk    (clk),
    .rst    (rst),
    .vld_i  (dec_vld_i),
    .code_i (dec_p8_i),
    .vld_o  (dec_vld_o),
    .f32_o  (dec_f32_o)
  );
endmodule

// File: tb/tb_posit8_fp32_bridge.sv
`timescale 1ns/1ps
module tb_posit8_fp32_bridge;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        ev = 1'b0, dv = 1'b0;
  logic [31:0] ex1 = '0, ex2 = '0;
  logic [7:0]  dx = '0;
  logic        evo1, evo2, dvo1, dvo2;
  logic [7:0]  ep1, ep2;
  logic [31:0] df1, df2;

  posit8_fp32_bridge #(.ES(1)) dut (
    .clk(clk), .rst(rst),
    .enc_vld_i(ev), .enc_f32_i(ex1), .enc_vld_o(evo1), .enc_p8_o(ep1),
    .dec_vld_i(dv), .dec_p8_i(dx), .dec_vld_o(dvo1), .dec_f32_o(df1));

  posit8_fp32_bridge #(.ES(2)) dut_e2 (
    .clk(clk), .rst(rst),
    .enc_vld_i(ev), .enc_f32_i(ex2), .enc_vld_o(evo2), .enc_p8_o(ep2),
    .dec_vld_i(dv), .dec_p8_i(dx), .dec_vld_o(dvo2), .dec_f32_o(df2));

  int nchk = 0, nfail = 0;
  bit done = 0;

  // pending expectations for the outputs one clock later
  logic        pe_v = 0, pd_v = 0;
  logic [7:0]  pe1 = '0, pe2 = '0;
  logic [31:0] pd1 = '0, pd2 = '0;
  string       te = "R1", td = "R1";

  function automatic real pow2(input int e);
    real r = 1.0;
    if (e >= 0) for (int i = 0; i < e; i++) r = r * 2.0;
    else        for (int i = 0; i < -e; i++) r = r / 2.0;
    return r;
  endfunction

  // behavioural value of an n-bit posit (n = 8 or 9), not-a-real excluded
  function automatic real pval(input int code, input int n, input int es);
    int c = code, idx, m, k, e;
    bit r0, neg;
    real f, w;
    if (c == 0) return 0.0;
    neg = c[n-1];
    if (neg) c = (1 << n) - c;
    idx = n - 2; r0 = c[idx]; m = 0;
    while (idx >= 0 && c[idx] == r0) begin m++; idx--; end
    if (idx >= 0) idx--;
    k = r0 ? m - 1 : -m;
    e = 0;
    for (int j = 0; j < es; j++) begin
      e = e * 2 + ((idx >= 0) ? int'(c[idx]) : 0);
      idx--;
    end
    f = 1.0; w = 0.5;
    while (idx >= 0) begin
      if (c[idx]) f = f + w;
      w = w / 2.0; idx--;
    end
    f = f * pow2(k * (1 << es) + e);
    return neg ? -f : f;
  endfunction

  function automatic logic [31:0] r2f(input real v);
    logic s;
    int e;
    real a;
    if (v == 0.0) return 32'h0;
    s = (v < 0.0);
    a = s ? -v : v;
    e = 0;
    while (a >= 2.0) begin a = a / 2.0; e++; end
    while (a < 1.0)  begin a = a * 2.0; e--; end
    return {s, 8'(e + 127), 23'(longint'((a - 1.0) * 8388608.0))};
  endfunction

  function automatic real f2r(input logic [31:0] x);
    real r;
    if (x[30:23] == 8'h00) r = real'(x[22:0]) * pow2(-149);
    else r = (1.0 + real'(x[22:0]) / 8388608.0) * pow2(int'(x[30:23]) - 127);
    return x[31] ? -r : r;
  endfunction

  function automatic logic [31:0] dec_ref(input int code, input int es);
    if (code == 128) return 32'h7FC0_0000;
    return r2f(pval(code, 8, es));
  endfunction

  function automatic logic [7:0] enc_ref(input logic [31:0] x, input int es);
    real v, lo, hi, mid;
    int mag = 1;
    if (x[30:23] == 8'hFF) return 8'h80;
    if (x[30:0] == 31'h0)  return 8'h00;
    v = f2r({1'b0, x[30:0]});
    if (v >= pow2(6 * (1 << es)))       mag = 127;
    else if (v <= pow2(-6 * (1 << es))) mag = 1;
    else begin
      for (int c = 1; c < 127; c++) begin
        lo = pval(c, 8, es); hi = pval(c + 1, 8, es);
        if (v >= lo && v < hi) begin
          mid = pval(2 * c + 1, 9, es);
          if (v > mid)       mag = c + 1;
          else if (v == mid) mag = (c % 2 == 0) ? c : c + 1;
          else               mag = c;
        end
      end
    end
    return x[31] ? 8'(256 - mag) : 8'(mag);
  endfunction

  task automatic chk(input string nm, input string tag, input logic vo, input logic ve,
                     input logic [31:0] d, input logic [31:0] de);
    nchk++;
    if (vo !== ve || d !== de) begin
      nfail++;
      $display("FAIL %s %s: vld=%0b data=%h expected vld=%0b data=%h", tag, nm, vo, d, ve, de);
    end
  endtask

  task automatic apply(input logic e_v, input logic [31:0] x1, input logic [31:0] x2,
                       input logic [7:0] ee1, input logic [7:0] ee2, input string etag,
                       input logic d_v, input logic [7:0] dcode, input string dtag);
    @(negedge clk);
    chk("enc es1", te, evo1, pe_v, {24'h0, ep1}, {24'h0, pe1});
    chk("enc es2", te, evo2, pe_v, {24'h0, ep2}, {24'h0, pe2});
    chk("dec es1", td, dvo1, pd_v, df1, pd1);
    chk("dec es2", td, dvo2, pd_v, df2, pd2);
    ev = e_v; ex1 = x1; ex2 = x2; dv = d_v; dx = dcode;
    pe_v = e_v; pd_v = d_v;
    if (e_v) begin pe1 = ee1; pe2 = ee2; te = etag; end else te = "R1";
    if (d_v) begin
      pd1 = dec_ref(int'(dcode), 1); pd2 = dec_ref(int'(dcode), 2); td = dtag;
    end else td = "R1";
  endtask

  task automatic enc_both(input logic [31:0] x1, input logic [31:0] x2, input string tag);
    apply(1'b1, x1, x2, enc_ref(x1, 1), enc_ref(x2, 2), tag, 1'b0, 8'h00, "R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf = 32'h1234_5679;
    logic [31:0] m1, m2;
    string dtag;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: first comparison sees the reset state (pending expects vld 0 / data 0)
    // R2 R3 R4 decode of all codes, R8 round trip on the encode path
    for (int c = 0; c < 256; c++) begin
      if (c == 0 || c == 128) dtag = "R3";
      else if (c >= 128)      dtag = "R4";
      else                    dtag = "R2";
      apply(1'b1, dec_ref(c, 1), dec_ref(c, 2), 8'(c), 8'(c), "R8", 1'b1, 8'(c), dtag);
    end
    // R7 specials
    enc_both(32'h0000_0000, 32'h0000_0000, "R7");
    enc_both(32'h8000_0000, 32'h8000_0000, "R7");
    enc_both(32'h7F80_0000, 32'hFF80_0000, "R7");
    enc_both(32'h7FC0_0000, 32'h7F80_0001, "R7");
    // R6 saturation, subnormals
    enc_both(32'h7F7F_FFFF, 32'hFF7F_FFFF, "R6");
    enc_both(32'h0000_0001, 32'h8040_0000, "R6");
    enc_both(32'h807F_FFFF, 32'h0000_0100, "R6");
    enc_both(32'h3000_0000, 32'hB000_0000, "R6");
    enc_both(r2f(pow2(12)), r2f(pow2(24)), "R6");
    enc_both(r2f(-pow2(-12)), r2f(-pow2(-24)), "R6");
    // R9: same input, different exponent width
    enc_both(r2f(pow2(12)), r2f(pow2(12)), "R9");
    enc_both(r2f(pow2(-13)), r2f(pow2(-13)), "R9");
    // an idle cycle between bursts (R1 hold)
    apply(1'b0, 32'h0, 32'h0, 8'h0, 8'h0, "R1", 1'b0, 8'h0, "R1");
    // R5 pattern midpoints and their neighbours, both signs
    for (int c = 1; c < 127; c++) begin
      m1 = r2f(pval(2 * c + 1, 9, 1));
      m2 = r2f(pval(2 * c + 1, 9, 2));
      for (int d = -1; d <= 1; d++) begin
        enc_both(m1 + 32'(d), m2 + 32'(d), "R5");
        enc_both({1'b1, m1[30:0] + 31'(d)}, {1'b1, m2[30:0] + 31'(d)}, "R5");
      end
    end
    // R5 R1 random values with gapped valids on both paths
    for (int i = 0; i < 1000; i++) begin
      logic [31:0] x;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      x = {lf[31], 8'(127 + int'(lf[28:23]) - 32), lf[22:0]};
      apply(lf[0] | lf[1], x, x, enc_ref(x, 1), enc_ref(x, 2), "R5",
            lf[2], lf[10:3], lf[10] ? "R4" : "R2");
    end
    apply(1'b0, 32'h0, 32'h0, 8'h0, 8'h0, "R1", 1'b0, 8'h0, "R1");
    apply(1'b0, 32'h0, 32'h0, 8'h0, 8'h0, "R1", 1'b0, 8'h0, "R1");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule